// File: doc/BRIEF.md
# Indexed Colour-Grading Table Port

This block is a byte-wide register front end that gives indirect access to six colour-grading lookup tables kept in on-chip storage. A host writes a switch byte that picks the table and the access mode, writes an index byte, and then moves 16-bit entries through two value bytes. Hue-to-hue entries are 14-bit signed; the other five tables hold 12-bit unsigned entries. Applying the tables to pixels is left to other logic.

The register offsets are 0 (switch), 1 (index low byte), 2 (value low byte) and 3 (value high byte). A small two-state machine tracks a staged high byte. ST_IDLE moves to ST_STAGED on a write to offset 3. ST_STAGED stays in ST_STAGED on another write to offset 3, and returns to ST_IDLE on a write to offset 2, which commits the entry. In ST_IDLE a write to offset 2 commits with a zero high byte and the state stays in ST_IDLE. In bulk mode every access to offset 2 advances the index, so a table streams as repeated high/low pairs.

Top module: `cg_table_port`

## Requirements
- R1: After reset, reads of all four offsets return 0 and every table entry reads as 0.
- R2: A read (bus_rd high) updates bus_rdata at the next rising clock edge. bus_rdata holds its value in every cycle without a read.
- R3: Switch bits 7:5 select the table (0 hue-hue, 1 hue-sat, 2 light-sat, 3 sat-sat, 4 light-light, 5 hue-light). Bits 4:1 are index bits 11:8 and bit 0 is the bulk flag. Offset 0 reads back the switch byte and offset 1 reads back index bits 7:0.
- R4: Only index bits 5:0 pick the entry (64 per table), and index bits 11:6 have no effect on which entry is accessed.
- R5: A write to offset 3 only stages the high byte, and the addressed entry is unchanged until the next write to offset 2. That write stores {staged byte, low byte} in one step.
- R6: A write to offset 2 with no staged high byte stores the entry with a high byte of 0.
- R7: Tables 1 to 5 keep bits 11:0 of a written word, and their bits 15:12 read as 0.
- R8: Table 0 keeps bits 13:0 of a written word, and on read bit 13 is copied into bits 15:14.
- R9: With switch codes 6 or 7, offsets 2 and 3 read 0, and writes to offset 2 change no table.
- R10: With bulk flag 1, each read or write of offset 2 increments the 12-bit index by one after the access, carrying into switch bits 4:1 and wrapping from 0xFFF to 0. Accesses to offset 3 and all accesses with bulk flag 0 leave the index as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset 0..3 |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume each strobe describes one whole access, with the offset and write data stable across that cycle. The bench drives every access as a single-cycle strobe on the falling edge and drops it on the next falling edge. Its tasks never raise both strobes at once, so the index-step and staging properties see one operation per edge. Reserved table codes and index values above 63 are driven on purpose, because the properties have to hold on those inputs too.

// File: rtl/cg_pkg.sv
package cg_pkg;

    typedef enum logic [1:0] {
        OFS_SWITCH = 2'd0,
        OFS_INDEX  = 2'd1,
        OFS_VAL_LO = 2'd2,
        OFS_VAL_HI = 2'd3
    } reg_ofs_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STAGED = 1'b1
    } stage_state_e;

    typedef struct packed {
        logic [2:0] table_sel;
        logic [3:0] idx_hi;
        logic       bulk;
    } switch_t;

endpackage

// File: rtl/cg_ctrl.sv
module cg_ctrl
    import cg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            addr,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [2:0]            table_sel,
    output logic [BYTE_W+3:0]     index,
    output logic                  commit,
    output logic [2*BYTE_W-1:0]   commit_word,
    output logic [BYTE_W-1:0]     sw_byte,
    output logic [BYTE_W-1:0]     idx_byte
);
    localparam int IDX_W = BYTE_W + 4;

    stage_state_e      state_q, state_d;
    switch_t           sw_q;
    logic [BYTE_W-1:0] idx_lo_q;
    logic [BYTE_W-1:0] hold_q;
    logic              lo_hit, hi_hit, step;
    logic [IDX_W-1:0]  index_next;

    assign lo_hit     = (reg_ofs_e'(addr) == OFS_VAL_LO);
    assign hi_hit     = (reg_ofs_e'(addr) == OFS_VAL_HI);
    assign step       = sw_q.bulk && lo_hit && (wr || rd);
    assign index      = {sw_q.idx_hi, idx_lo_q};
    assign index_next = index + IDX_W'(1);
    assign table_sel  = sw_q.table_sel;
    assign sw_byte    = sw_q;
    assign idx_byte   = idx_lo_q;
    assign commit     = wr && lo_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr && hi_hit) state_d = ST_STAGED;
            ST_STAGED: if (wr && lo_hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the machine: the word committed on a low-byte write
    always_comb begin
        unique case (state_q)
            ST_STAGED: commit_word = {hold_q, wdata};
            default:   commit_word = {{BYTE_W{1'b0}}, wdata};
        endcase
    end

    // switch, index and staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q     <= '0;
            idx_lo_q <= '0;
            hold_q   <= '0;
        end else begin
            if (wr && reg_ofs_e'(addr) == OFS_SWITCH) begin
                sw_q <= switch_t'(wdata);
            end else if (wr && reg_ofs_e'(addr) == OFS_INDEX) begin
                idx_lo_q <= wdata;
            end else if (step) begin
                sw_q.idx_hi <= index_next[IDX_W-1:BYTE_W];
                idx_lo_q    <= index_next[BYTE_W-1:0];
            end
            if (wr && hi_hit) hold_q <= wdata;
        end
    end

    p_stage_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hi_hit) |=> (state_q == ST_STAGED));

    p_commit_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && lo_hit) |=> (state_q == ST_IDLE));

    p_bulk_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (index == $past(index) + IDX_W'(1)));

    p_normal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !step) |=> $stable(index));

endmodule

// File: rtl/cg_table_bank.sv
module cg_table_bank #(
    parameter int TABLES     = 6,
    parameter int DEPTH_BITS = 6,
    parameter int HUE_W      = 14,
    parameter int SAT_W      = 12,
    parameter int WORD_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            sel,
    input  logic [DEPTH_BITS-1:0] entry,
    input  logic                  we,
    input  logic [WORD_W-1:0]     wword,
    output logic [WORD_W-1:0]     rword
);
    localparam int DEPTH = 1 << DEPTH_BITS;

    logic [WORD_W-1:0] rd_arr [TABLES];

    for (genvar t = 0; t < TABLES; t++) begin : g_tbl
        localparam int W = (t == 0) ? HUE_W : SAT_W;
        logic [W-1:0] mem [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && sel == 3'(t)) begin
                mem[entry] <= wword[W-1:0];
            end
        end

        if (t == 0) begin : g_signed
            assign rd_arr[t] = {{(WORD_W-W){mem[entry][W-1]}}, mem[entry]};
        end else begin : g_unsigned
            assign rd_arr[t] = {{(WORD_W-W){1'b0}}, mem[entry]};
        end
    end

    always_comb begin
        rword = '0;
        for (int t = 0; t < TABLES; t++) begin
            if (sel == 3'(t)) rword = rd_arr[t];
        end
    end

    p_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != 3'd0 && int'(sel) < TABLES) |-> (rword[WORD_W-1:SAT_W] == '0));

endmodule

// File: rtl/cg_table_port.sv
module cg_table_port
    import cg_pkg::*;
#(
    parameter int TABLES     = 6,
    parameter int DEPTH_BITS = 6,
    parameter int HUE_W      = 14,
    parameter int SAT_W      = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int IDX_W  = BYTE_W + 4;

    logic [2:0]        table_sel;
    logic [IDX_W-1:0]  index;
    logic              commit;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] rword;
    logic [BYTE_W-1:0] sw_byte, idx_byte;
    logic [BYTE_W-1:0] rdata_q;

    cg_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .wdata       (bus_wdata),
        .table_sel   (table_sel),
        .index       (index),
        .commit      (commit),
        .commit_word (commit_word),
        .sw_byte     (sw_byte),
        .idx_byte    (idx_byte)
    );

    cg_table_bank #(
        .TABLES     (TABLES),
        .DEPTH_BITS (DEPTH_BITS),
        .HUE_W      (HUE_W),
        .SAT_W      (SAT_W),
        .WORD_W     (WORD_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (table_sel),
        .entry (index[DEPTH_BITS-1:0]),
        .we    (commit),
        .wword (commit_word),
        .rword (rword)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            unique case (reg_ofs_e'(bus_addr))
                OFS_SWITCH: rdata_q <= sw_byte;
                OFS_INDEX:  rdata_q <= idx_byte;
                OFS_VAL_LO: rdata_q <= rword[BYTE_W-1:0];
                OFS_VAL_HI: rdata_q <= rword[WORD_W-1:BYTE_W];
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1] && int'(table_sel) >= TABLES) |=> (bus_rdata == '0));

endmodule

// File: tb/sim_cg_table_port.sv
module sim_cg_table_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit comparing = 1'b0;
    string cur_req = "R1";
    string edge_req = "R1";

    // behavioural reference state
    logic [15:0] m_mem [0:7][0:63];
    logic [7:0]  m_sw, m_ilo, m_hold, m_exp;
    bit          m_staged;

    always #4 clk = ~clk;

    cg_table_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] m_read(logic [2:0] s, int e);
        logic [15:0] v;
        if (s > 3'd5) return 16'h0000;
        v = m_mem[s][e];
        if (s == 3'd0 && v[13]) v = v | 16'hC000;
        return v;
    endfunction

    always @(posedge clk) begin
        logic [11:0] ix;
        logic [15:0] cur, word;
        logic [2:0]  s;
        cycles++;
        edge_req = cur_req;
        if (!rst_n) begin
            for (int t = 0; t < 8; t++)
                for (int e = 0; e < 64; e++) m_mem[t][e] = 16'h0;
            m_sw = 0; m_ilo = 0; m_hold = 0; m_exp = 0; m_staged = 0;
        end else begin
            ix  = {m_sw[4:1], m_ilo};
            s   = m_sw[7:5];
            cur = m_read(s, int'(ix[5:0]));
            if (bus_rd) begin
                case (bus_addr)
                    2'd0: m_exp = m_sw;
                    2'd1: m_exp = m_ilo;
                    2'd2: m_exp = cur[7:0];
                    default: m_exp = cur[15:8];
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: m_sw = bus_wdata;
                    2'd1: m_ilo = bus_wdata;
                    2'd3: begin m_hold = bus_wdata; m_staged = 1; end
                    default: begin
                        word = {(m_staged ? m_hold : 8'h00), bus_wdata};
                        if (s == 3'd0)     m_mem[s][ix[5:0]] = word & 16'h3FFF;
                        else if (s < 3'd6) m_mem[s][ix[5:0]] = word & 16'h0FFF;
                        m_staged = 0;
                    end
                endcase
            end
            if (ix == {m_sw[4:1], m_ilo} && m_sw[0] && bus_addr == 2'd2 && (bus_wr || bus_rd)) begin
                ix = ix + 12'd1;
                m_sw[4:1] = ix[11:8];
                m_ilo = ix[7:0];
            end
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (comparing && !done) begin
            checks++;
            if (bus_rdata !== m_exp) begin
                failures++;
                $display("FAIL %s: bus_rdata actual=%h expected=%h at cycle %0d",
                         edge_req, bus_rdata, m_exp, cycles);
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input string req);
        cur_req = req; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input string req);
        cur_req = req; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] w, input string req);
        wr_reg(2'd3, w[15:8], req);
        wr_reg(2'd2, w[7:0], req);
    endtask

    task automatic rd_word(input string req);
        rd_reg(2'd3, req);
        rd_reg(2'd2, req);
    endtask

    task automatic point(input logic [7:0] sw, input logic [7:0] ilo, input string req);
        wr_reg(2'd0, sw, req);
        wr_reg(2'd1, ilo, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (bus_rdata !== 8'h00) begin
            failures++;
            $display("FAIL R1: rdata in reset actual=%h expected=00", bus_rdata);
        end
        rst_n = 1'b1;
        @(negedge clk);
        comparing = 1'b1;

        // R1: reset values
        for (int a = 0; a < 4; a++) rd_reg(2'(a), "R1");
        // R3: switch and index readback, table separation
        point(8'h5A, 8'h37, "R3");
        rd_reg(2'd0, "R3"); rd_reg(2'd1, "R3");
        for (int t = 0; t < 6; t++) begin
            point(8'(t << 5), 8'h09, "R3");
            wr_word(16'h0100 + 16'(t * 17), "R3");
        end
        for (int t = 0; t < 6; t++) begin
            point(8'(t << 5), 8'h09, "R3");
            rd_word("R3");
        end
        // R2: quiet cycles keep the last read value
        repeat (4) @(negedge clk);
        cur_req = "R2";
        repeat (3) @(negedge clk);
        // R5: staging is not visible until the low byte lands
        point(8'h20, 8'h05, "R5");
        wr_reg(2'd3, 8'h0A, "R5");
        rd_word("R5");
        wr_reg(2'd3, 8'h0B, "R5");
        rd_word("R5");
        wr_reg(2'd2, 8'hBC, "R5");
        rd_word("R5");
        // R6: lone low-byte write
        point(8'h20, 8'h06, "R6");
        wr_word(16'h0722, "R6");
        rd_word("R6");
        wr_reg(2'd2, 8'h33, "R6");
        rd_word("R6");
        // R7: twelve-bit tables drop the top nibble
        for (int t = 1; t < 6; t++) begin
            point(8'(t << 5), 8'h3F, "R7");
            wr_word(16'hFFFF, "R7");
            rd_word("R7");
        end
        // R8: hue table sign extension
        point(8'h00, 8'h10, "R8");
        wr_word(16'h3FFF, "R8"); rd_word("R8");
        wr_word(16'h1FFF, "R8"); rd_word("R8");
        wr_word(16'hE000, "R8"); rd_word("R8");
        wr_word(16'h8000, "R8"); rd_word("R8");
        wr_word(16'h2001, "R8"); rd_word("R8");
        // R4: upper index bits alias
        point(8'h00, 8'h40, "R4");
        wr_word(16'h0ABC, "R4");
        point(8'h00, 8'h00, "R4"); rd_word("R4");
        point(8'h02, 8'hC1, "R4"); wr_word(16'h0123, "R4");
        point(8'h00, 8'h01, "R4"); rd_word("R4");
        // R9: reserved table codes
        point(8'hC0, 8'h09, "R9");
        wr_word(16'h0FAB, "R9"); rd_word("R9");
        point(8'hE0, 8'h09, "R9");
        wr_word(16'h0FCD, "R9"); rd_word("R9");
        for (int t = 0; t < 6; t++) begin
            point(8'(t << 5), 8'h09, "R9");
            rd_word("R9");
        end
        // R10: bulk stream write and read, then index readback
        point(8'h21, 8'h00, "R10");
        for (int k = 0; k < 5; k++) wr_word(16'h0200 + 16'(k * 3), "R10");
        rd_reg(2'd1, "R10"); rd_reg(2'd0, "R10");
        wr_reg(2'd1, 8'h00, "R10");
        for (int k = 0; k < 5; k++) rd_word("R10");
        rd_reg(2'd1, "R10");
        rd_reg(2'd3, "R10"); rd_reg(2'd3, "R10"); rd_reg(2'd1, "R10");
        // R10: carry into switch bits and wrap
        point(8'h21, 8'hFF, "R10");
        rd_reg(2'd2, "R10"); rd_reg(2'd0, "R10"); rd_reg(2'd1, "R10");
        point(8'h3F, 8'hFF, "R10");
        wr_reg(2'd2, 8'h44, "R10");
        rd_reg(2'd0, "R10"); rd_reg(2'd1, "R10");
        point(8'h20, 8'h3F, "R10"); rd_word("R10");
        // R10: normal mode leaves index alone
        point(8'h20, 8'h07, "R10");
        rd_reg(2'd2, "R10"); wr_reg(2'd2, 8'h55, "R10");
        rd_reg(2'd1, "R10");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule